// File: doc/BRIEF.md
# Port Overload Fault Timer

This block guards one powered port, and a chip places one copy beside each port. When the port is switched on, the block times a start-up window. During that window it counts the milliseconds that carry an overload. Too many such milliseconds end the start-up with a fault. A clean window leaves the port marked good. After the window, a leaky up/down counter watches for continued overload, so that brief, sparse overloads are tolerated and a sustained one trips the port.

An overload is an overcurrent, or a port voltage that is out of its allowed band. A protection clamp that engages trips the port at once. Every trip raises a power-off command. The command holds until the port request is withdrawn, and withdrawing the request also clears all timing state. Sensing and the policy for re-enabling the port belong to neighbouring logic.

Top module: `ovl_fault_timer`

## Requirements
- R1: While the asynchronous active-low reset is applied, and after it is released with the request low, pwr_off, start_ovl_evt, run_ovl_evt and pgood_start are all 0.
- R2: A rising port_on_req starts a start-up window of 60 ms_tick pulses. In the cycle after the edge that samples the 60th tick, if no start-up fault has occurred, pgood_start goes to 1 and stays 1 while the port runs.
- R3: If a 55th overload tick is counted inside the start-up window, start_ovl_evt pulses high for one cycle after that edge and pwr_off goes to 1. This takes priority over the end of the window. With 54 overload ticks the window ends normally.
- R4: A tick counts as an overload when ovc_flag or vout_bad is 1, either one alone being enough.
- R5: After the window, each overload tick raises a level by 1. When the level reaches 60, run_ovl_evt pulses for one cycle, pwr_off goes to 1 and pgood_start goes to 0.
- R6: Every 16th tick without overload lowers the level by 1. A pattern of 1 overload tick in 17 therefore never trips the port, while 1 in 16 eventually does.
- R7: The level saturates at zero. Ticks without overload at level 0 leave exactly 60 overload ticks needed to trip.
- R8: clamp_on while the port is in its start-up window or running produces run_ovl_evt and pwr_off in the next cycle, without waiting for a tick and without start_ovl_evt.
- R9: pwr_off holds while port_on_req stays 1. A low port_on_req returns all outputs to 0 in the next cycle and clears every counter, so that a new request starts from empty counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_on_req | input | 1 | Request to power the port |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| ovc_flag | input | 1 | Current above the cut limit |
| vout_bad | input | 1 | Port voltage outside its allowed band |
| clamp_on | input | 1 | Protection clamp engaged |
| pwr_off | output | 1 | Command to remove port power (held) |
| start_ovl_evt | output | 1 | One-cycle start-up overload event |
| run_ovl_evt | output | 1 | One-cycle running overload event |
| pgood_start | output | 1 | Port survived its start-up window |

## Verification
The bench puts 55 overload ticks on the very last tick of the start-up window. A design that let the window end first would report power-good and miss the fault. A count of 54 must pass, which exposes an off-by-one in the tolerance. For the running filter, a 1-in-17 overload pattern held for many periods catches a decrement that is too slow, and a 1-in-16 pattern that must trip catches one that is too fast. Sixty overload ticks after a long quiet stretch catch a level that wraps below zero. A request dropped with the level at 59 must leave no residue, or the next run would trip after one overload tick.

// File: rtl/ovl_timer_pkg.sv
package ovl_timer_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_START = 2'd1,
        PS_RUN   = 2'd2,
        PS_FAULT = 2'd3
    } port_state_e;

    typedef struct packed {
        port_state_e state;
        logic        pwr_off;
        logic        start_evt;
        logic        run_evt;
        logic        pgood;
    } ctl_regs_t;

endpackage

// File: rtl/ovl_start_window.sv
module ovl_start_window #(
    parameter int WIN_MS      = 60,
    parameter int START_TOL_MS = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic ovl,
    output logic trip_now,
    output logic done_now
);
    localparam int HIT_LIM = WIN_MS - START_TOL_MS;
    localparam int CW      = $clog2(WIN_MS + 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WIN_MS - 1);
    localparam logic [CW-1:0] HIT_LAST = CW'(HIT_LIM - 1);

    typedef struct packed {
        logic [CW-1:0] win;
        logic [CW-1:0] hits;
    } win_regs_t;

    win_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en) begin
            r_d.win  = '0;
            r_d.hits = '0;
        end else if (tick) begin
            if (r_q.win != CW'(WIN_MS))
                r_d.win = r_q.win + 1'b1;
            if (ovl && r_q.hits != CW'(HIT_LIM))
                r_d.hits = r_q.hits + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trip_now = en && tick && ovl && (r_q.hits == HIT_LAST);
    assign done_now = en && tick && (r_q.win == WIN_LAST);

endmodule

// File: rtl/ovl_run_filter.sv
module ovl_run_filter #(
    parameter int TRIP_MS  = 60,
    parameter int DOWN_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic ovl,
    output logic trip_now
);
    localparam int LW = $clog2(TRIP_MS + 1);
    localparam int DW = (DOWN_DIV > 1) ? $clog2(DOWN_DIV) : 1;
    localparam logic [LW-1:0] LVL_MAX  = LW'(TRIP_MS);
    localparam logic [LW-1:0] LVL_LAST = LW'(TRIP_MS - 1);
    localparam logic [DW-1:0] DIV_LAST = DW'(DOWN_DIV - 1);

    typedef struct packed {
        logic [LW-1:0] lvl;
        logic [DW-1:0] div;
    } flt_regs_t;

    flt_regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (!en) begin
            r_d.lvl = '0;
            r_d.div = '0;
        end else if (tick) begin
            if (ovl) begin
                if (r_q.lvl != LVL_MAX)
                    r_d.lvl = r_q.lvl + 1'b1;
            end else if (r_q.div == DIV_LAST) begin
                r_d.div = '0;
                if (r_q.lvl != '0)
                    r_d.lvl = r_q.lvl - 1'b1;
            end else begin
                r_d.div = r_q.div + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign trip_now = en && tick && ovl && (r_q.lvl == LVL_LAST);

endmodule

// File: rtl/ovl_fault_timer.sv
module ovl_fault_timer
    import ovl_timer_pkg::*;
#(
    parameter int WIN_MS       = 60,
    parameter int START_TOL_MS = 5,
    parameter int TRIP_MS      = 60,
    parameter int DOWN_DIV     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic port_on_req,
    input  logic ms_tick,
    input  logic ovc_flag,
    input  logic vout_bad,
    input  logic clamp_on,
    output logic pwr_off,
    output logic start_ovl_evt,
    output logic run_ovl_evt,
    output logic pgood_start
);
    ctl_regs_t c_d, c_q;

    logic ovl;
    logic win_en, run_en;
    logic win_trip, win_done, run_trip;

    assign ovl    = ovc_flag | vout_bad;
    assign win_en = port_on_req && (c_q.state == PS_START);
    assign run_en = port_on_req && (c_q.state == PS_RUN);

    ovl_start_window #(
        .WIN_MS       (WIN_MS),
        .START_TOL_MS (START_TOL_MS)
    ) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (win_en),
        .tick     (ms_tick),
        .ovl      (ovl),
        .trip_now (win_trip),
        .done_now (win_done)
    );

    ovl_run_filter #(
        .TRIP_MS  (TRIP_MS),
        .DOWN_DIV (DOWN_DIV)
    ) u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .tick     (ms_tick),
        .ovl      (ovl),
        .trip_now (run_trip)
    );

    always_comb begin
        c_d           = c_q;
        c_d.start_evt = 1'b0;
        c_d.run_evt   = 1'b0;
        unique case (c_q.state)
            PS_OFF: begin
                c_d.pwr_off = 1'b0;
                c_d.pgood   = 1'b0;
                if (port_on_req) c_d.state = PS_START;
            end
            PS_START: begin
                if (!port_on_req) begin
                    c_d.state = PS_OFF;
                end else if (clamp_on) begin
                    c_d.state   = PS_FAULT;
                    c_d.run_evt = 1'b1;
                    c_d.pwr_off = 1'b1;
                end else if (win_trip) begin
                    c_d.state     = PS_FAULT;
                    c_d.start_evt = 1'b1;
                    c_d.pwr_off   = 1'b1;
                end else if (win_done) begin
                    c_d.state = PS_RUN;
                    c_d.pgood = 1'b1;
                end
            end
            PS_RUN: begin
                if (!port_on_req) begin
                    c_d.state = PS_OFF;
                    c_d.pgood = 1'b0;
                end else if (clamp_on || run_trip) begin
                    c_d.state   = PS_FAULT;
                    c_d.run_evt = 1'b1;
                    c_d.pwr_off = 1'b1;
                    c_d.pgood   = 1'b0;
                end
            end
            PS_FAULT: begin
                if (!port_on_req) begin
                    c_d.state   = PS_OFF;
                    c_d.pwr_off = 1'b0;
                end
            end
            default: c_d.state = PS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state     <= PS_OFF;
            c_q.pwr_off   <= 1'b0;
            c_q.start_evt <= 1'b0;
            c_q.run_evt   <= 1'b0;
            c_q.pgood     <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pwr_off       = c_q.pwr_off;
    assign start_ovl_evt = c_q.start_evt;
    assign run_ovl_evt   = c_q.run_evt;
    assign pgood_start   = c_q.pgood;

endmodule

// File: rtl/ovl_fault_timer_chk.sv
module ovl_fault_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic port_on_req,
    input logic ms_tick,
    input logic pwr_off,
    input logic start_ovl_evt,
    input logic run_ovl_evt,
    input logic pgood_start
);
    AST_START_EVT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        start_ovl_evt |-> pwr_off); // R3
    AST_START_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        start_ovl_evt |=> !start_ovl_evt); // R3
    AST_RUN_EVT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        run_ovl_evt |-> (pwr_off && !pgood_start)); // R5
    AST_RUN_EVT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        run_ovl_evt |=> !run_ovl_evt); // R8
    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({start_ovl_evt, run_ovl_evt}) <= 1); // R8
    AST_PG_NOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        pgood_start |-> !pwr_off); // R2
    AST_PG_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood_start) |-> $past(ms_tick) && $past(port_on_req)); // R2
    AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_off && port_on_req) |=> pwr_off); // R9
    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !port_on_req |=> (!pwr_off && !pgood_start && !start_ovl_evt && !run_ovl_evt)); // R9
endmodule

bind ovl_fault_timer ovl_fault_timer_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .port_on_req   (port_on_req),
    .ms_tick       (ms_tick),
    .pwr_off       (pwr_off),
    .start_ovl_evt (start_ovl_evt),
    .run_ovl_evt   (run_ovl_evt),
    .pgood_start   (pgood_start)
);

// File: tb/ovl_fault_timer_tb_top.sv
module ovl_fault_timer_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic port_on_req = 1'b0, ms_tick = 1'b0, ovc_flag = 1'b0, vout_bad = 1'b0, clamp_on = 1'b0;
    logic pwr_off, start_ovl_evt, run_ovl_evt, pgood_start;

    int n_cmp = 0;
    int n_bad = 0;
    logic seen_r, seen_s;

    always #5 clk = ~clk;

    ovl_fault_timer dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_on_req   (port_on_req),
        .ms_tick       (ms_tick),
        .ovc_flag      (ovc_flag),
        .vout_bad      (vout_bad),
        .clamp_on      (clamp_on),
        .pwr_off       (pwr_off),
        .start_ovl_evt (start_ovl_evt),
        .run_ovl_evt   (run_ovl_evt),
        .pgood_start   (pgood_start)
    );

    // fields: count[16:9] on tick ovc vbad clamp | exp {off, sevt, revt, pg}
    localparam int NV = 22;
    localparam logic [16:0] VEC [NV] = '{
        {8'd1,  5'b00000, 4'b0000},  // R1 idle
        {8'd1,  5'b10000, 4'b0000},  // R2 request
        {8'd59, 5'b11000, 4'b0000},  // R2 window not over
        {8'd1,  5'b11000, 4'b0001},  // R2 window ends
        {8'd59, 5'b11100, 4'b0001},  // R5 level 59
        {8'd16, 5'b11000, 4'b0001},  // R6 down to 58
        {8'd1,  5'b11100, 4'b0001},  // R5 59
        {8'd1,  5'b11010, 4'b1010},  // R4 R5 trip via voltage flag
        {8'd3,  5'b10000, 4'b1000},  // R9 hold
        {8'd1,  5'b00000, 4'b0000},  // R9 release
        {8'd1,  5'b10000, 4'b0000},  // R3 request
        {8'd54, 5'b11100, 4'b0000},  // R3 54 hits
        {8'd5,  5'b11000, 4'b0000},  // R3 window at 59
        {8'd1,  5'b11100, 4'b1100},  // R3 55th hit on last tick
        {8'd1,  5'b00000, 4'b0000},  // R9
        {8'd1,  5'b10000, 4'b0000},  // R3 request
        {8'd53, 5'b11100, 4'b0000},  // R3
        {8'd6,  5'b11000, 4'b0000},  // R3
        {8'd1,  5'b11100, 4'b0001},  // R3 54 hits passes
        {8'd1,  5'b10001, 4'b1010},  // R8 clamp while running
        {8'd1,  5'b10000, 4'b1000},  // R9
        {8'd1,  5'b00000, 4'b0000}   // R9
    };

    task automatic report;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: {off,sevt,revt,pg} actual=%b expected=%b", req, act, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {pwr_off, start_ovl_evt, run_ovl_evt, pgood_start};
    endfunction

    task automatic step(input logic on, input logic tk, input logic oc, input logic vb, input logic cl);
        @(negedge clk);
        port_on_req = on; ms_tick = tk; ovc_flag = oc; vout_bad = vb; clamp_on = cl;
        @(posedge clk);
        #2;
        if (run_ovl_evt) seen_r = 1'b1;
        if (start_ovl_evt) seen_s = 1'b1;
    endtask

    task automatic power_up;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 60; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete");
        report();
        $finish;
    end

    initial begin
        seen_r = 1'b0; seen_s = 1'b0;
        repeat (3) @(posedge clk);
        #2 check("R1 during reset", outs(), 4'b0000);
        @(negedge clk) rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < int'(VEC[v][16:9]); k++)
                step(VEC[v][8], VEC[v][7], VEC[v][6], VEC[v][5], VEC[v][4]);
            check($sformatf("vector %0d", v), outs(), VEC[v][3:0]);
        end

        // R6: 1 overload in 17 ticks never trips
        power_up();
        check("R2 powered", outs(), 4'b0001);
        seen_r = 1'b0;
        for (int p = 0; p < 120; p++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
            for (int q = 0; q < 16; q++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        check("R6 1-in-17 no trip", {seen_r, pwr_off, pgood_start, 1'b0}, 4'b0010);
        // R6: 1 overload in 16 ticks eventually trips
        for (int p = 0; p < 1400 && !seen_r; p++) begin
            step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
            for (int q = 0; q < 15 && !seen_r; q++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        end
        check("R6 1-in-16 trips", {seen_r, pwr_off, 2'b00}, 4'b1100);

        // R7: saturation at zero
        power_up();
        for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        seen_r = 1'b0;
        for (int i = 0; i < 59; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 59 hits after quiet", {seen_r, pwr_off, pgood_start, 1'b0}, 4'b0010);
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        check("R7 60th hit trips", outs(), 4'b1010);

        // R9: dropping the request clears the running level
        power_up();
        for (int i = 0; i < 59; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R9 drop clears pg", outs(), 4'b0000);
        power_up();
        check("R9 restart window", outs(), 4'b0001);
        seen_r = 1'b0;
        for (int i = 0; i < 59; i++) step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
        check("R9 level was cleared", {seen_r, pwr_off, pgood_start, 1'b0}, 4'b0010);

        // R8: clamp during start-up window, no tick
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 5; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
        check("R8 clamp in start-up", outs(), 4'b1010);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R8 event is one cycle", outs(), 4'b1000);

        // R1: reset mid-fault
        @(negedge clk) rst_n = 1'b0;
        #2 check("R1 async reset", outs(), 4'b0000);
        @(negedge clk) rst_n = 1'b1;
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R1 after reset", outs(), 4'b0000);

        report();
        $finish;
    end
endmodule